// File: doc/BRIEF.md
# I2C Bus Recovery Pulse Sequencer

A device on an I2C bus that was part-way through a transfer when the system reset can keep SDA low and block every later transaction. This block works through the existing I2C controller to free it, because it has no direct access to the pins. It sets the controller's enable, start and transmit controls high together and then drops them, for a fixed number of rounds. Each round makes the controller attempt a START condition, which clocks the stuck device forward until it lets go of the bus.

The length of each high and low phase follows the controller's current 6-bit frequency-divider code. When the go pulse is accepted, the block splits the code into two table indices and looks up an SDA hold tap and an SCL (base, step) pair. It computes the phase length in microseconds once, at that moment. A free-running microsecond tick then times every phase. After the last round the controls settle with only enable high, and a one-cycle done pulse marks that point.

Top module: `i2c_unstick_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no go pulse, the enable, start and transmit outputs and done are all low. A reset in the middle of a sequence returns the outputs to this state.
- R2: A go pulse sampled while the block is idle sets enable, start and transmit high in the next cycle.
- R3: A sequence has 9 rounds. Each round is one phase with enable, start and transmit all high, followed by one phase with all three low. The high and low phases alternate strictly.
- R4: Every phase lasts exactly D microsecond ticks, where D = base + (h − 1) × step + 3. The SDA hold-tap index is {code[5], code[1:0]}, and hold taps h for indices 0..7 are 3,3,4,4,1,1,2,2. The SCL pair index is code[4:2], and the (base, step) pairs for indices 0..7 are (4,1),(4,2),(6,4),(6,8),(14,16),(30,32),(62,64),(126,128).
- R5: A clock cycle without a tick does not advance a phase, so the length of a phase in clock cycles scales with the tick spacing.
- R6: After the ninth low phase, enable stays high and start and transmit stay low until the next accepted go pulse.
- R7: done is high for exactly one clock: the first cycle in which the enable-only state is shown. It is low at all other times.
- R8: A go pulse sampled during a sequence has no effect. This includes a go pulse at the clock edge that ends the ninth low phase.
- R9: The divider code is sampled only when a go pulse is accepted. Changes to the code during a sequence do not alter the phase length.
- R10: A go pulse sampled in the settled enable-only state starts a new sequence, with all three controls high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Request to start a recovery sequence (one-cycle pulse) |
| div_code_i | input | 6 | Controller frequency-divider code |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| ctl_en_o | output | 1 | Controller enable control |
| ctl_start_o | output | 1 | Controller start-request control |
| ctl_tx_o | output | 1 | Controller transmit-direction control |
| done_o | output | 1 | One-cycle pulse when the sequence has finished |

## Verification
Two events can meet in the same cycle: the end of the last low phase, which moves the block to its settled state, and a fresh go pulse, which could restart it. The bench holds the tick high on every cycle so that it knows the exact edge at which the final low phase ends. It places a single go pulse on that edge. The outputs must become enable-only with done high, and they must stay there in the next cycle instead of restarting. A go pulse one cycle later, in the settled state, must then restart the sequence.

// File: rtl/i2c_unstick_pkg.sv
`timescale 1ns/1ps
package i2c_unstick_pkg;

   // sequencer phase
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_DRIVE   = 2'd1,
      PH_RELEASE = 2'd2,
      PH_PARKED  = 2'd3
   } phase_e;

   // control bundle driven toward the I2C controller
   typedef struct packed {
      logic en;
      logic start;
      logic tx;
   } ctl_t;

endpackage

// File: rtl/i2c_unstick_delay.sv
`timescale 1ns/1ps
// Phase length (in microseconds) derived from the divider code.
module i2c_unstick_delay #(
   parameter int CODE_W = 6,
   parameter int DLY_W  = 10
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DLY_W-1:0]  delay_o
);

   generate
      if (CODE_W != 6) begin : g_bad_code
         $error("i2c_unstick_delay: CODE_W must be 6");
      end
      if (DLY_W < 10) begin : g_bad_dly
         $error("i2c_unstick_delay: DLY_W must hold 513");
      end
   endgenerate

   logic [2:0]       hold_idx;
   logic [2:0]       pair_idx;
   logic [DLY_W-1:0] hold_m1;
   logic [DLY_W-1:0] base;
   logic [DLY_W-1:0] step;

   assign hold_idx = {code_i[5], code_i[1:0]};
   assign pair_idx = code_i[4:2];

   // hold tap minus one
   always_comb begin
      case (hold_idx)
         3'd0, 3'd1: hold_m1 = DLY_W'(2);
         3'd2, 3'd3: hold_m1 = DLY_W'(3);
         3'd4, 3'd5: hold_m1 = DLY_W'(0);
         default:    hold_m1 = DLY_W'(1);
      endcase
   end

   always_comb begin
      case (pair_idx)
         3'd0, 3'd1: base = DLY_W'(4);
         3'd2, 3'd3: base = DLY_W'(6);
         3'd4:       base = DLY_W'(14);
         3'd5:       base = DLY_W'(30);
         3'd6:       base = DLY_W'(62);
         default:    base = DLY_W'(126);
      endcase
   end

   // step doubles with each pair index
   assign step    = DLY_W'(1) << pair_idx;
   assign delay_o = base + hold_m1 * step + DLY_W'(3);

endmodule

// File: rtl/i2c_unstick_timer.sv
`timescale 1ns/1ps
// Down-counter of microsecond ticks for one phase.
module i2c_unstick_timer #(
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic             expire_o,
   output logic [DLY_W-1:0] count_o
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i && cnt_q != '0) begin
         cnt_q <= cnt_q - DLY_W'(1);
      end
   end

   assign expire_o = tick_i && (cnt_q == DLY_W'(1));
   assign count_o  = cnt_q;

   // R5
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_unstick_fsm.sv
`timescale 1ns/1ps
// Round/phase sequencing and control decode.
module i2c_unstick_fsm
   import i2c_unstick_pkg::*;
#(
   parameter int ROUNDS = 9
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go_i,
   input  logic   expire_i,
   output logic   accept_o,
   output logic   reload_o,
   output phase_e phase_o,
   output ctl_t   ctl_o,
   output logic   done_o
);

   localparam int RND_W = $clog2(ROUNDS + 1);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

   generate
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("i2c_unstick_fsm: ROUNDS must be at least 1");
      end
   endgenerate

   phase_e           ph_q, ph_d;
   logic [RND_W-1:0] rnd_q, rnd_d;
   logic             done_q, done_d;
   logic             last_round;

   assign last_round = (rnd_q == LAST_RND);
   assign accept_o   = go_i && (ph_q == PH_IDLE || ph_q == PH_PARKED);

   always_comb begin
      ph_d     = ph_q;
      rnd_d    = rnd_q;
      done_d   = 1'b0;
      reload_o = 1'b0;
      unique case (ph_q)
         PH_IDLE, PH_PARKED: begin
            if (go_i) begin
               ph_d  = PH_DRIVE;
               rnd_d = '0;
            end
         end
         PH_DRIVE: begin
            if (expire_i) begin
               ph_d     = PH_RELEASE;
               reload_o = 1'b1;
            end
         end
         PH_RELEASE: begin
            if (expire_i) begin
               if (last_round) begin
                  ph_d   = PH_PARKED;
                  done_d = 1'b1;
               end else begin
                  ph_d     = PH_DRIVE;
                  rnd_d    = rnd_q + RND_W'(1);
                  reload_o = 1'b1;
               end
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         rnd_q  <= '0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         rnd_q  <= rnd_d;
         done_q <= done_d;
      end
   end

   always_comb begin
      ctl_o.en    = (ph_q == PH_DRIVE) || (ph_q == PH_PARKED);
      ctl_o.start = (ph_q == PH_DRIVE);
      ctl_o.tx    = (ph_q == PH_DRIVE);
   end

   assign phase_o = ph_q;
   assign done_o  = done_q;

   // R3
   round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_q <= LAST_RND);

   // R3
   drive_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DRIVE && expire_i) |=> (ph_q == PH_RELEASE));

   // R2
   start_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && go_i) |=> (ctl_o.start && ctl_o.tx && ctl_o.en));

   // R6
   parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PARKED && !go_i) |=> (ph_q == PH_PARKED));

   // R8
   busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RELEASE && !expire_i) |=> (ph_q == PH_RELEASE && $stable(rnd_q)));

   // R7
   done_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (ctl_o.en && !ctl_o.start && !ctl_o.tx && $past(ph_q) == PH_RELEASE));

endmodule

// File: rtl/i2c_unstick_seq.sv
`timescale 1ns/1ps
// I2C bus recovery pulse sequencer (top).
module i2c_unstick_seq
   import i2c_unstick_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int DLY_W  = 10,
   parameter int ROUNDS = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic              us_tick_i,
   output logic              ctl_en_o,
   output logic              ctl_start_o,
   output logic              ctl_tx_o,
   output logic              done_o
);

   logic [DLY_W-1:0] dly_now;
   logic [DLY_W-1:0] dly_q;
   logic [DLY_W-1:0] load_val;
   logic [DLY_W-1:0] tmr_count;
   logic             accept;
   logic             reload;
   logic             expire;
   phase_e           phase;
   ctl_t             ctl;

   i2c_unstick_delay #(
      .CODE_W (CODE_W),
      .DLY_W  (DLY_W)
   ) u_delay (
      .code_i  (div_code_i),
      .delay_o (dly_now)
   );

   // phase length captured once per accepted go
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q <= '0;
      end else if (accept) begin
         dly_q <= dly_now;
      end
   end

   assign load_val = accept ? dly_now : dly_q;

   i2c_unstick_timer #(
      .DLY_W (DLY_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept | reload),
      .load_val_i (load_val),
      .tick_i     (us_tick_i),
      .expire_o   (expire),
      .count_o    (tmr_count)
   );

   i2c_unstick_fsm #(
      .ROUNDS (ROUNDS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go_i),
      .expire_i (expire),
      .accept_o (accept),
      .reload_o (reload),
      .phase_o  (phase),
      .ctl_o    (ctl),
      .done_o   (done_o)
   );

   assign ctl_en_o    = ctl.en;
   assign ctl_start_o = ctl.start;
   assign ctl_tx_o    = ctl.tx;

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DRIVE || phase == PH_RELEASE) |-> (tmr_count <= dly_q && tmr_count != '0));

   // R9
   dly_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RELEASE && !expire) |=> $stable(dly_q));

endmodule

// File: tb/i2c_unstick_seq_test.sv
`timescale 1ns/1ps
module i2c_unstick_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       go = 1'b0;
   logic [5:0] div_code = 6'd0;
   logic       tick = 1'b0;
   logic       en, st, tx, done;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   i2c_unstick_seq uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .div_code_i  (div_code),
      .us_tick_i   (tick),
      .ctl_en_o    (en),
      .ctl_start_o (st),
      .ctl_tx_o    (tx),
      .done_o      (done)
   );

   // code, expected ticks per phase, tick spacing in clocks, poke mid-run
   localparam int NV = 10;
   localparam logic [5:0] V_CODE [NV] = '{6'h00, 6'h3F, 6'h20, 6'h1F, 6'h05,
                                          6'h0A, 6'h2D, 6'h32, 6'h17, 6'h3B};
   localparam int V_DLY [NV] = '{9, 257, 7, 513, 11, 21, 9, 33, 129, 129};
   localparam int V_PER [NV] = '{1, 1, 3, 1, 2, 1, 3, 1, 2, 1};
   localparam bit V_POKE[NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
                                 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one full sequence, watched at every falling edge
   task automatic run_seq(input logic [5:0] code, input int per, input int exp_d,
                          input bit poke);
      int       ticks = 0;
      int       phases = 0;
      int       tcnt = 0;
      int       cyc = 0;
      bit       tprev;
      bit       in_seq = 0;
      bit       fin = 0;
      logic [2:0] cur = 3'b000;
      logic [2:0] o;
      logic [2:0] exp_o;
      @(negedge clk);
      div_code = code;
      go = 1'b1;
      tick = (per == 1);
      tprev = tick;
      while (!fin && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         go = 1'b0;
         o = {en, st, tx};
         if (in_seq && tprev) ticks++;
         if (!in_seq) begin
            chk(o == 3'b111, "R2 start", int'(o), 7);
            in_seq = 1;
            cur = o;
            ticks = 0;
         end else if (o != cur) begin
            chk(ticks == exp_d, (per > 1) ? "R4/R5 phase ticks" : "R4 phase ticks",
                ticks, exp_d);
            phases++;
            exp_o = (phases == 18) ? 3'b100 : ((phases % 2) == 1 ? 3'b000 : 3'b111);
            chk(o == exp_o, "R3 phase order", int'(o), int'(exp_o));
            if (phases >= 18) begin
               chk(done == 1'b1, "R7 done at park", int'(done), 1);
               fin = 1;
            end
            cur = o;
            ticks = 0;
         end
         if (!fin && done) chk(1'b0, "R7 early done", 1, 0);
         if (poke && phases == 5 && ticks == 1) begin
            go = 1'b1;
            div_code = ~code;
         end
         tcnt = (tcnt + 1) % per;
         tick = (tcnt == per - 1);
         tprev = tick;
      end
      chk(phases == 18, poke ? "R8/R9 phase count" : "R3 phase count", phases, 18);
      div_code = code;
      @(negedge clk);
      chk({en, st, tx} == 3'b100, "R6 parked", int'({en, st, tx}), 4);
      chk(done == 1'b0, "R7 single pulse", int'(done), 0);
      tick = 1'b1;
      repeat (20) @(negedge clk);
      chk({en, st, tx} == 3'b100, "R6 parked hold", int'({en, st, tx}), 4);
      tick = 1'b0;
   endtask

   initial begin : watchdog
      #600000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({en, st, tx, done} == 4'b0000, "R1 in reset", int'({en, st, tx, done}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({en, st, tx, done} == 4'b0000, "R1 after reset", int'({en, st, tx, done}), 0);

      for (int i = 0; i < NV; i++) begin
         run_seq(V_CODE[i], V_PER[i], V_DLY[i], V_POKE[i]);
      end

      // R8: go on the edge that ends the ninth low phase (code 0x20, 7 ticks)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({en, st, tx, done} == 4'b0000, "R1 mid reset", int'({en, st, tx, done}), 0);
      rst_n = 1'b1;
      tick = 1'b1;
      div_code = 6'h20;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk({en, st, tx} == 3'b111, "R2 idle start", int'({en, st, tx}), 7);
      repeat (18 * 7 - 1) @(negedge clk);
      chk({en, st, tx} == 3'b000, "R3 last low", int'({en, st, tx}), 0);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk({en, st, tx} == 3'b100, "R8 collide park", int'({en, st, tx}), 4);
      chk(done == 1'b1, "R7 collide done", int'(done), 1);
      @(negedge clk);
      chk({en, st, tx} == 3'b100, "R8 collide no restart", int'({en, st, tx}), 4);
      chk(done == 1'b0, "R7 collide done drop", int'(done), 0);

      // R10: restart from parked state
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk({en, st, tx} == 3'b111, "R10 restart", int'({en, st, tx}), 7);
      for (int k = 0; k < 400 && !done; k++) @(negedge clk);
      chk(done == 1'b1 && {en, st, tx} == 3'b100, "R10 restart finishes",
          int'({done, en, st, tx}), 12);
      tick = 1'b0;
      @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule